// File: doc/BRIEF.md
# Local Bus Hold/Release Arbiter

This block governs when a bridge that masters a local processor bus may drive that bus. It raises a hold request, waits for the external arbiter's hold acknowledge, and only then enables its bus drivers. While it owns the bus, a request from a competing local master can take the bus away. This happens only during a preemptible transfer (a DMA move or a slave-side write), and the bus is handed over after a bounded number of further word transfers.

An optional gating mode delays the handover until a latency timer has run out. The latency timer is reloaded each time ownership is gained. After a handover, a pause timer must reach zero and the acknowledge must be seen low before the hold request is raised again. The transfer then resumes where it stopped, and a word position counter keeps its value across the interruption. No data passes through the block.

Top module: `local_hold_arbiter`

## Requirements
- R1: During and right after reset, `hold`, `drv_en` and `word_pos` are all zero.
- R2: From idle, `xfer_active` high raises `hold` after the next clock edge. `drv_en` stays low while no `hold_ack` has been sampled.
- R3: `drv_en` rises on the edge after `hold_ack` is sampled high while `hold` is high. If `hold_ack` is sampled low during ownership, `drv_en` falls on the next edge and `hold` stays high to request the bus again.
- R4: With gating off, an `other_req` during a preemptible transfer is honoured on the edge where it is sampled. Counting that edge, at most REL_WORDS (default 2) `word_done` strobes are accepted before `hold` and `drv_en` fall together.
- R5: `other_req` has no effect while `xfer_preempt` is low.
- R6: With `gate_en` high, the latency timer loads `lat_load` when ownership is gained and counts down once per owned cycle. A request is honoured only after the timer reaches zero, which is no earlier than the (lat_load+1)-th edge after `drv_en` rises.
- R7: After a release, the pause timer loads `pause_load` and counts down once per cycle. `hold` is raised again on the first edge at which the timer is zero and `hold_ack` is sampled low.
- R8: `word_pos` counts `word_done` strobes sampled while `drv_en` is high. It keeps its value across a release and a regain.
- R9: `xfer_active` low drops `hold` and `drv_en` and clears `word_pos` on the next edge.
- R10: `word_done` strobes sampled while `drv_en` is low leave `word_pos` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_active | input | 1 | A transfer is pending and needs the bus |
| xfer_preempt | input | 1 | The current transfer may be preempted (DMA or slave write) |
| word_done | input | 1 | One word moved on the bus this cycle |
| other_req | input | 1 | Another local master requests the bus |
| hold_ack | input | 1 | Hold acknowledge from the local arbiter |
| gate_en | input | 1 | 1: honour requests only after the latency timer expires |
| lat_load | input | LAT_W | Latency timer reload value |
| pause_load | input | PAUSE_W | Pause timer reload value |
| hold | output | 1 | Hold request to the local arbiter |
| drv_en | output | 1 | Output enable for the bus drivers |
| word_pos | output | POS_W | Words moved in the current transfer |

## Verification
An internal state that is wrong shows up as `hold` or `drv_en` toggling on the wrong edge. Because both outputs are registered decodes of the next state, this is visible one cycle after the cause. A latency or pause timer that is off by one moves the release or re-request edge by exactly one cycle, so the bench counts edges from the rise of `drv_en` and from the release. A release counter that is wrong shows up as a `word_pos` value at the drop of `drv_en` that differs from the expected count.

// File: rtl/lha_pkg.sv
package lha_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_OWN   = 3'd2,
    ST_REL   = 3'd3,
    ST_PAUSE = 3'd4
  } lha_state_e;
endpackage

// File: rtl/lha_timer.sv
module lha_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R6 / R7: a reload takes the supplied value
  p_load_value_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));

  // R6 / R7: one step per enabled cycle, never below zero
  p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && dec && cnt != '0) |=> cnt == $past(cnt) - W'(1));
endmodule

// File: rtl/lha_fsm.sv
module lha_fsm
  import lha_pkg::*;
#(
  parameter int REL_WORDS = 2,
  parameter int POS_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_active,
  input  logic             xfer_preempt,
  input  logic             word_done,
  input  logic             other_req,
  input  logic             hold_ack,
  input  logic             gate_en,
  input  logic             lat_zero,
  input  logic             pause_zero,
  output logic             lat_load_en,
  output logic             lat_dec,
  output logic             pause_load_en,
  output logic             pause_dec,
  output logic             hold,
  output logic             drv_en,
  output logic [POS_W-1:0] word_pos
);
  localparam int REL_CW = $clog2(REL_WORDS + 1);

  lha_state_e        st, nxt;
  logic [REL_CW-1:0] rel_cnt;
  logic [REL_CW:0]   rel_sum;
  logic              preempt;

  assign preempt = other_req && xfer_preempt && (!gate_en || lat_zero);
  assign rel_sum = {1'b0, rel_cnt} + (REL_CW+1)'(word_done);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (xfer_active) nxt = ST_REQ;
      ST_REQ: begin
        if (!xfer_active)  nxt = ST_IDLE;
        else if (hold_ack) nxt = ST_OWN;
      end
      ST_OWN: begin
        if (!xfer_active)   nxt = ST_IDLE;
        else if (!hold_ack) nxt = ST_REQ;
        else if (preempt)   nxt = (word_done && REL_WORDS <= 1) ? ST_PAUSE : ST_REL;
      end
      ST_REL: begin
        if (!xfer_active)   nxt = ST_IDLE;
        else if (!hold_ack) nxt = ST_REQ;
        else if (rel_sum >= (REL_CW+1)'(REL_WORDS)) nxt = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (!xfer_active)                nxt = ST_IDLE;
        else if (pause_zero && !hold_ack) nxt = ST_REQ;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign lat_load_en   = (st == ST_REQ) && (nxt == ST_OWN);
  assign lat_dec       = (st == ST_OWN);
  assign pause_load_en = (nxt == ST_PAUSE) && (st != ST_PAUSE);
  assign pause_dec     = (st == ST_PAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rel_cnt  <= '0;
      hold     <= 1'b0;
      drv_en   <= 1'b0;
      word_pos <= '0;
    end else begin
      st     <= nxt;
      hold   <= (nxt == ST_REQ) || (nxt == ST_OWN) || (nxt == ST_REL);
      drv_en <= (nxt == ST_OWN) || (nxt == ST_REL);
      if (st == ST_OWN && nxt == ST_REL)  rel_cnt <= REL_CW'(word_done);
      else if (st == ST_REL && word_done) rel_cnt <= rel_cnt + REL_CW'(1);
      if (nxt == ST_IDLE)              word_pos <= '0;
      else if (word_done && drv_en)    word_pos <= word_pos + POS_W'(1);
    end
  end

  // R3: drivers enabled only under an acknowledged hold
  p_drv_under_hold_r3: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> hold);
  p_drv_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> $past(hold_ack));
  // R4: release counter never reaches the bound while still releasing
  p_rel_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REL) |-> rel_cnt < REL_CW'(REL_WORDS));
  // R6: no release start while gated and the latency timer is running
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OWN && gate_en && !lat_zero) |=> st != ST_REL);
  // R7: re-request from pause only with timer at zero and ack low
  p_rerequest_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REQ && $past(st) == ST_PAUSE) |-> ($past(pause_zero) && !$past(hold_ack)));
  // R9: a finished transfer drops the bus on the next edge
  p_idle_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !xfer_active |=> (!hold && !drv_en && word_pos == '0));
  // R10: position frozen while not driving
  p_pos_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (nxt != ST_IDLE && !drv_en) |=> $stable(word_pos));
endmodule

// File: rtl/local_hold_arbiter.sv
module local_hold_arbiter #(
  parameter int LAT_W     = 8,
  parameter int PAUSE_W   = 8,
  parameter int REL_WORDS = 2,
  parameter int POS_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xfer_active,
  input  logic               xfer_preempt,
  input  logic               word_done,
  input  logic               other_req,
  input  logic               hold_ack,
  input  logic               gate_en,
  input  logic [LAT_W-1:0]   lat_load,
  input  logic [PAUSE_W-1:0] pause_load,
  output logic               hold,
  output logic               drv_en,
  output logic [POS_W-1:0]   word_pos
);
  logic lat_load_en, lat_dec, lat_zero;
  logic pause_load_en, pause_dec, pause_zero;

  lha_timer #(.W(LAT_W)) u_lat (
    .clk(clk), .rst(rst), .load(lat_load_en), .load_val(lat_load),
    .dec(lat_dec), .zero(lat_zero)
  );

  lha_timer #(.W(PAUSE_W)) u_pause (
    .clk(clk), .rst(rst), .load(pause_load_en), .load_val(pause_load),
    .dec(pause_dec), .zero(pause_zero)
  );

  lha_fsm #(.REL_WORDS(REL_WORDS), .POS_W(POS_W)) u_fsm (
    .clk(clk), .rst(rst),
    .xfer_active(xfer_active), .xfer_preempt(xfer_preempt),
    .word_done(word_done), .other_req(other_req), .hold_ack(hold_ack),
    .gate_en(gate_en), .lat_zero(lat_zero), .pause_zero(pause_zero),
    .lat_load_en(lat_load_en), .lat_dec(lat_dec),
    .pause_load_en(pause_load_en), .pause_dec(pause_dec),
    .hold(hold), .drv_en(drv_en), .word_pos(word_pos)
  );

  // R1: quiet outputs right after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!hold && !drv_en && word_pos == '0));
endmodule

// File: tb/tb_local_hold_arbiter.sv
module tb_local_hold_arbiter;
  localparam int LAT_W = 8, PAUSE_W = 8, POS_W = 16, NV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xa = 0, xp = 0, wd = 0, orq = 0, ha = 0, ge = 0;
  logic [LAT_W-1:0]   lat = '0;
  logic [PAUSE_W-1:0] pau = '0;
  logic hold, drv_en;
  logic [POS_W-1:0] word_pos;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  local_hold_arbiter #(.LAT_W(LAT_W), .PAUSE_W(PAUSE_W), .REL_WORDS(2), .POS_W(POS_W)) dut (
    .clk(clk), .rst(rst), .xfer_active(xa), .xfer_preempt(xp), .word_done(wd),
    .other_req(orq), .hold_ack(ha), .gate_en(ge), .lat_load(lat), .pause_load(pau),
    .hold(hold), .drv_en(drv_en), .word_pos(word_pos)
  );

  // {xa,xp,wd,orq,ha} , {hold,drv_en} , pos ; gate off, pause_load = 2
  localparam logic [14:0] VEC [NV] = '{
    {5'b11000, 2'b10, 8'd0}, {5'b11000, 2'b10, 8'd0}, {5'b11001, 2'b11, 8'd0},
    {5'b11101, 2'b11, 8'd1}, {5'b11101, 2'b11, 8'd2}, {5'b10111, 2'b11, 8'd3},
    {5'b10011, 2'b11, 8'd3}, {5'b11011, 2'b11, 8'd3}, {5'b11111, 2'b11, 8'd4},
    {5'b11101, 2'b00, 8'd5}, {5'b11001, 2'b00, 8'd5}, {5'b11001, 2'b00, 8'd5},
    {5'b11001, 2'b00, 8'd5}, {5'b11000, 2'b10, 8'd5}, {5'b11001, 2'b11, 8'd5},
    {5'b11101, 2'b11, 8'd6}, {5'b11000, 2'b10, 8'd6}, {5'b11100, 2'b10, 8'd6},
    {5'b11001, 2'b11, 8'd6}, {5'b01000, 2'b00, 8'd0}
  };
  localparam string TAG [NV] = '{
    "R2", "R2", "R3", "R8", "R8", "R5", "R5", "R4", "R4", "R4",
    "R7", "R7", "R7", "R7", "R8", "R8", "R3", "R10", "R8", "R9"
  };

  task automatic chk(input string req, input logic eh, input logic ed, input logic [POS_W-1:0] ep);
    checks++;
    if (hold !== eh || drv_en !== ed || word_pos !== ep) begin
      failures++;
      $display("FAIL %s: actual hold=%0b drv_en=%0b pos=%0d expected hold=%0b drv_en=%0b pos=%0d",
               req, hold, drv_en, word_pos, eh, ed, ep);
    end
  endtask

  task automatic step(input logic [4:0] in);
    @(negedge clk);
    {xa, xp, wd, orq, ha} = in;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {xa, xp, wd, orq, ha} = 5'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pau = 8'd2; lat = 8'd5; ge = 1'b0;
    do_reset();
    chk("R1", 1'b0, 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14:10]);
      chk(TAG[i], VEC[i][9], VEC[i][8], POS_W'(VEC[i][7:0]));
    end

    // R6: gated release waits for the latency timer (lat_load = 3)
    do_reset();
    ge = 1'b1; lat = 8'd3; pau = 8'd0;
    step(5'b11011); chk("R2", 1'b1, 1'b0, '0);
    step(5'b11011); chk("R6", 1'b1, 1'b1, '0);
    for (int k = 1; k <= 3; k++) begin
      step(5'b11111); chk("R6", 1'b1, 1'b1, POS_W'(k));
    end
    step(5'b11111); chk("R6", 1'b1, 1'b1, POS_W'(4));
    step(5'b11111); chk("R6", 1'b0, 1'b0, POS_W'(5));
    // R7: pause_load = 0 and ack low re-request on the next edge
    step(5'b11000); chk("R7", 1'b1, 1'b0, POS_W'(5));

    // R4: ungated, strobe in the honouring cycle counts toward the bound
    do_reset();
    ge = 1'b0; pau = 8'd1;
    step(5'b11011); chk("R2", 1'b1, 1'b0, '0);
    step(5'b11011); chk("R3", 1'b1, 1'b1, '0);
    step(5'b11111); chk("R4", 1'b1, 1'b1, POS_W'(1));
    step(5'b11111); chk("R4", 1'b0, 1'b0, POS_W'(2));
    // R7: pause_load = 1 with ack low -> low one more edge, then hold
    step(5'b11000); chk("R7", 1'b0, 1'b0, POS_W'(2));
    step(5'b11000); chk("R7", 1'b1, 1'b0, POS_W'(2));

    // R1: reset in the middle of an owned transfer
    step(5'b11001); chk("R3", 1'b1, 1'b1, POS_W'(2));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", 1'b0, 1'b0, '0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule